// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block collects up to 64 device interrupt sources into one shared pending register and steers them to four processors. Each processor owns an enable mask. The requests a processor actually sees are its mask ANDed with the shared pending bits. That per-processor vector is driven live on an output bus. A registered summary line per processor tells the core that at least one enabled source is pending.

Device-side logic sets and clears pending bits through two bit-vector strobes. Software reaches the block over a plain address/data bus. Every access carries a size code. The block decodes 64-byte-spaced register slots from the distance between the access address and a base address. Software may rewrite the masks. The request and pending slots can be read but not written. Any malformed access is answered with a one-cycle error pulse.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, every mask, the pending register and all request vectors are zero, and `cpu_irq`, `bus_err`, `bus_rvalid` and `src_spurious` are low.
- R2: For every processor c, `cpu_active` slice c (bits 64c+63..64c) always equals mask c AND the pending register, and a read of slot 4+c returns the same value.
- R3: A 1 on `src_set` bit n sets pending bit n at that clock edge, and every processor whose mask bit n is 1 shows bit n active from the next cycle.
- R4: A 1 on `src_clr` bit n clears pending bit n and withdraws n from every processor. If pending bit n was 0 and `src_set` bit n is 0, nothing changes and `src_spurious` pulses for one cycle. When set and clear of the same bit coincide, the set wins.
- R5: A legal write to slot c (0..3) replaces mask c. Bits newly enabled while pending become active, and bits disabled while active are withdrawn, both from the next cycle.
- R6: The slot index is (bus_addr − BASE_ADDR) >> 6. Slots 0..3 are masks, 4..7 are request vectors and 8 is the pending register. Any other index, and any address below the base, raises `bus_err` and reads return zero.
- R7: Only size code 3 (64-bit) is legal. Codes 0, 1 and 2 (8, 16, 32 bit) raise `bus_err`, change no state and read as zero.
- R8: Writes to slots 4..8 raise `bus_err` and change neither the pending register nor any mask. The pending register changes only through the device strobes.
- R9: `cpu_irq` bit c is the OR of processor c's request vector, delayed by one register stage.
- R10: A read presents `bus_rvalid` and `bus_rdata` in the cycle after the access, holding the state from before any update made at that same edge. `bus_err` also appears in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bit |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the access |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | Illegal access pulse |
| src_set | input | 64 | Per-source set strobes |
| src_clr | input | 64 | Per-source clear strobes |
| src_spurious | output | 1 | Pulse: a clear hit a source that was not pending |
| cpu_active | output | 256 | Live request vector of each processor, 64 bits per processor |
| cpu_irq | output | 4 | Registered per-processor interrupt summary |

## Verification
Two kinds of event can meet in one clock: a mask write from the bus and a pending-bit update from the device strobes. A set and a clear of the same source can also meet. The bench drives a mask write to one processor in the same cycle as a set strobe for the source that mask enables. It then expects that source to be active for that processor in the very next cycle. It also drives set and clear together on one idle source and expects the bit to end up pending with no spurious pulse.

// File: rtl/irq_router_pkg.sv
// Package: shared encodings for the device interrupt router.
// Assumes a 64-bit data bus and 64-byte register spacing.
package irq_router_pkg;

    // Width of the register bus data path.
    localparam int BUS_W = 64;

    // Address bits dropped to form a slot index (64-byte spacing).
    localparam int SLOT_SHIFT = 6;

    // Size code of the only legal access width.
    localparam logic [1:0] SIZE_DWORD = 2'd3;

    // Kind of register a decoded slot refers to.
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_MASK = 2'd1,
        RK_REQ  = 2'd2,
        RK_RAW  = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Turns an address/size/direction into a register kind, a CPU index
// and a legality verdict. Purely combinational.
// Assumes slots 0..NUM_CPU-1 hold masks, NUM_CPU..2*NUM_CPU-1 hold
// request vectors and slot 2*NUM_CPU holds the shared pending register.
module irq_bus_decode
    import irq_router_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                NUM_CPU   = 4,
    localparam int               CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  cpu_idx,
    output logic              bad,
    output logic [NUM_CPU-1:0] mask_we
);

    localparam logic [ADDR_W-1:0] N_CPU_A  = ADDR_W'(NUM_CPU);
    localparam logic [ADDR_W-1:0] REQ_END  = ADDR_W'(2 * NUM_CPU);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] slot;
    logic              below_base;

    // Slot index from the distance to the base address.
    always_comb begin
        below_base = (addr < BASE_ADDR);
        offset     = addr - BASE_ADDR;
        slot       = offset >> SLOT_SHIFT;
    end

    // Classify the slot and pick the CPU it belongs to.
    always_comb begin
        kind    = RK_NONE;
        cpu_idx = '0;
        if (!below_base) begin
            if (slot < N_CPU_A) begin
                kind    = RK_MASK;
                cpu_idx = CPU_W'(slot);
            end else if (slot < REQ_END) begin
                kind    = RK_REQ;
                cpu_idx = CPU_W'(slot - N_CPU_A);
            end else if (slot == REQ_END) begin
                kind    = RK_RAW;
            end
        end
    end

    // Legality: full width, mapped slot, writes only to masks.
    always_comb begin
        bad = valid && ((size != SIZE_DWORD) || (kind == RK_NONE) ||
                        (write && (kind != RK_MASK)));
    end

    // One-hot mask write enables.
    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
            assign mask_we[c] = valid && write && !bad && (kind == RK_MASK) &&
                                (cpu_idx == CPU_W'(c));
        end
    endgenerate

endmodule

// File: rtl/irq_raw_reg.sv
// Module: irq_raw_reg
// Shared pending register updated by per-source set/clear strobes.
// A set wins over a clear on the same bit in the same cycle. A clear
// on a bit that is neither pending nor being set raises a one-cycle
// spurious pulse.
module irq_raw_reg #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_q,
    output logic               spur_q
);

    logic [NUM_SRC-1:0] raw_d;
    logic               spur_d;

    // Next pending state and spurious detection.
    always_comb begin
        raw_d  = (raw_q & ~clr_i) | set_i;
        spur_d = |(clr_i & ~raw_q & ~set_i);
    end

    // Pending register and spurious pulse flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            spur_q <= 1'b0;
        end else begin
            raw_q  <= raw_d;
            spur_q <= spur_d;
        end
    end

endmodule

// File: rtl/irq_cpu_slice.sv
// Module: irq_cpu_slice
// One processor's mask register, live request vector and registered
// interrupt summary. The request vector is mask AND pending at all times.
module irq_cpu_slice #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw_i,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] active,
    output logic               irq_q
);

    // Live request vector.
    always_comb begin
        active = mask_q & raw_i;
    end

    // Mask register, written whole on a legal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q <= wdata;
        end
    end

    // Registered interrupt summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |active;
        end
    end

endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Routes device interrupt sources to NUM_CPU processors through
// per-processor masks over a shared pending register, with a 64-bit
// register bus. Read data and error are registered one cycle after
// the access. Assumes NUM_SRC <= 64 and one access per cycle at most.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0001_0000,
    parameter int                NUM_CPU   = 4,
    parameter int                NUM_SRC   = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [1:0]                 bus_size,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       bus_rvalid,
    output logic                       bus_err,
    input  logic [NUM_SRC-1:0]         src_set,
    input  logic [NUM_SRC-1:0]         src_clr,
    output logic                       src_spurious,
    output logic [NUM_CPU*NUM_SRC-1:0] cpu_active,
    output logic [NUM_CPU-1:0]         cpu_irq
);

    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    reg_kind_e                       kind;
    logic [CPU_W-1:0]                cpu_idx;
    logic                            bad;
    logic [NUM_CPU-1:0]              mask_we;
    logic [NUM_SRC-1:0]              raw_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_arr;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] act_arr;
    logic [BUS_W-1:0]                rd_mux;

    irq_bus_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_CPU   (NUM_CPU)
    ) u_dec (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .size    (bus_size),
        .kind    (kind),
        .cpu_idx (cpu_idx),
        .bad     (bad),
        .mask_we (mask_we)
    );

    irq_raw_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_raw (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (src_clr),
        .raw_q  (raw_q),
        .spur_q (src_spurious)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            irq_cpu_slice #(
                .NUM_SRC (NUM_SRC)
            ) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .we     (mask_we[c]),
                .wdata  (bus_wdata[NUM_SRC-1:0]),
                .raw_i  (raw_q),
                .mask_q (mask_arr[c]),
                .active (act_arr[c]),
                .irq_q  (cpu_irq[c])
            );
        end
    endgenerate

    assign cpu_active = act_arr;

    // Readback selection by decoded register kind.
    always_comb begin
        unique case (kind)
            RK_MASK: rd_mux = BUS_W'(mask_arr[cpu_idx]);
            RK_REQ:  rd_mux = BUS_W'(act_arr[cpu_idx]);
            RK_RAW:  rd_mux = BUS_W'(raw_q);
            default: rd_mux = '0;
        endcase
    end

    // Registered bus response: data, read strobe and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            bus_err    <= bad;
            bus_rdata  <= (bus_valid && !bus_write && !bad) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Property checker for irq_router, attached by bind. Observes ports
// and the shared pending register.
module irq_router_chk #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_valid,
    input logic [1:0]                 bus_size,
    input logic                       bus_err,
    input logic [NUM_SRC-1:0]         src_set,
    input logic [NUM_SRC-1:0]         src_clr,
    input logic                       src_spurious,
    input logic [NUM_SRC-1:0]         raw_q,
    input logic [NUM_CPU*NUM_SRC-1:0] cpu_active,
    input logic [NUM_CPU-1:0]         cpu_irq
);

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_set) |=> ((raw_q & $past(src_set)) == $past(src_set))); // R3

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_clr & ~src_set)) |=> ((raw_q & $past(src_clr & ~src_set)) == '0)); // R4

    AST_SPUR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_clr & ~raw_q & ~src_set)) |=> src_spurious); // R4

    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|src_set) && !(|src_clr)) |=> $stable(raw_q)); // R8

    AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_size != 2'd3)) |=> bus_err); // R7

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
            AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (cpu_irq[c] == $past(|cpu_active[c*NUM_SRC +: NUM_SRC]))); // R9

            AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
                (|(src_clr & ~src_set)) |=>
                ((cpu_active[c*NUM_SRC +: NUM_SRC] & $past(src_clr & ~src_set)) == '0)); // R4
        end
    endgenerate

endmodule

bind irq_router irq_router_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_size     (bus_size),
    .bus_err      (bus_err),
    .src_set      (src_set),
    .src_clr      (src_clr),
    .src_spurious (src_spurious),
    .raw_q        (raw_q),
    .cpu_active   (cpu_active),
    .cpu_irq      (cpu_irq)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

    localparam logic [31:0] BASE = 32'h0001_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [1:0]   bus_size = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  bus_rdata;
    logic         bus_rvalid;
    logic         bus_err;
    logic [63:0]  src_set = '0;
    logic [63:0]  src_clr = '0;
    logic         src_spurious;
    logic [255:0] cpu_active;
    logic [3:0]   cpu_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [63:0] em [4];
    logic [63:0] er;
    logic [63:0] o_rd;
    logic        o_err, o_rv, o_spur;

    always #10 clk = ~clk;

    irq_router #(.BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .src_set(src_set), .src_clr(src_clr), .src_spurious(src_spurious),
        .cpu_active(cpu_active), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] slot_addr(input int idx);
        return BASE + 32'(idx * 64);
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = |(em[c] & er);
        return v;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One access/strobe cycle; outputs captured one cycle later.
    task automatic cyc(input logic v, input logic w, input logic [31:0] a,
                       input logic [1:0] sz, input logic [63:0] wd,
                       input logic [63:0] s, input logic [63:0] c);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
        bus_wdata = wd; src_set = s; src_clr = c;
        @(negedge clk);
        o_rd = bus_rdata; o_err = bus_err; o_rv = bus_rvalid; o_spur = src_spurious;
        bus_valid = 0; bus_write = 0; bus_wdata = '0; src_set = '0; src_clr = '0;
    endtask

    task automatic wr_mask(input int c, input logic [63:0] d);
        cyc(1, 1, slot_addr(c), 2'd3, d, '0, '0);
        em[c] = d;
        chk("R5", "mask write err", 64'(o_err), 64'(0));
    endtask

    task automatic chk_active(input string rq);
        for (int c = 0; c < 4; c++)
            chk(rq, $sformatf("active cpu%0d", c), cpu_active[c*64 +: 64], em[c] & er);
    endtask

    task automatic t_reset();
        chk("R1", "cpu_active", cpu_active[63:0] | cpu_active[127:64] |
            cpu_active[191:128] | cpu_active[255:192], '0);
        chk("R1", "cpu_irq", 64'(cpu_irq), 0);
        chk("R1", "err/rvalid/spur", {61'd0, bus_err, bus_rvalid, src_spurious}, 0);
        cyc(1, 0, slot_addr(8), 2'd3, '0, '0, '0);
        chk("R1", "raw read", o_rd, 0);
        chk("R10", "rvalid on read", 64'(o_rv), 1);
        cyc(1, 0, slot_addr(2), 2'd3, '0, '0, '0);
        chk("R1", "mask2 read", o_rd, 0);
    endtask

    task automatic t_mask_rw();
        wr_mask(0, 64'h0000_0000_0000_00F0);
        chk("R10", "no rvalid on write", 64'(o_rv), 0);
        wr_mask(1, 64'h0000_0000_0000_000F);
        wr_mask(2, '1);
        wr_mask(3, 64'h0);
        for (int c = 0; c < 4; c++) begin
            cyc(1, 0, slot_addr(c), 2'd3, '0, '0, '0);
            chk("R6", $sformatf("mask%0d readback", c), o_rd, em[c]);
        end
    endtask

    task automatic t_route();
        logic [63:0] s;
        s = 64'h8000_0000_0000_0012;
        cyc(0, 0, '0, 2'd3, '0, s, '0);
        er |= s;
        chk_active("R3");
        chk("R9", "irq one cycle late", 64'(cpu_irq), 0);
        @(negedge clk);
        chk("R9", "irq after stage", 64'(cpu_irq), 64'(exp_irq()));
        for (int c = 0; c < 4; c++) begin
            cyc(1, 0, slot_addr(4 + c), 2'd3, '0, '0, '0);
            chk("R2", $sformatf("req%0d read", c), o_rd, em[c] & er);
        end
        cyc(1, 0, slot_addr(8), 2'd3, '0, '0, '0);
        chk("R3", "raw read", o_rd, er);
    endtask

    task automatic t_clear();
        cyc(0, 0, '0, 2'd3, '0, '0, 64'h30);
        er &= ~64'h30;
        chk_active("R4");
        chk("R4", "spurious on idle bit 5", 64'(o_spur), 1);
        cyc(0, 0, '0, 2'd3, '0, '0, 64'h2);
        er &= ~64'h2;
        chk("R4", "no spurious on pending", 64'(o_spur), 0);
        chk_active("R4");
        cyc(0, 0, '0, 2'd3, '0, '0, 64'h2);
        chk("R4", "repeat clear spurious", 64'(o_spur), 1);
        cyc(1, 0, slot_addr(8), 2'd3, '0, '0, '0);
        chk("R4", "raw after clears", o_rd, er);
    endtask

    task automatic t_mask_edge();
        wr_mask(2, 64'h0);
        chk_active("R5");
        wr_mask(0, 64'h8000_0000_0000_0000);
        chk_active("R5");
        chk("R5", "cpu0 bit63 live", cpu_active[63:0], 64'h8000_0000_0000_0000);
    endtask

    task automatic t_size();
        for (int z = 0; z < 3; z++) begin
            cyc(1, 1, slot_addr(1), 2'(z), 64'hDEAD_BEEF_0000_FFFF, '0, '0);
            chk("R7", $sformatf("size %0d write err", z), 64'(o_err), 1);
            cyc(1, 0, slot_addr(1), 2'(z), '0, '0, '0);
            chk("R7", $sformatf("size %0d read err", z), 64'(o_err), 1);
            chk("R7", $sformatf("size %0d read zero", z), o_rd, 0);
        end
        cyc(1, 0, slot_addr(1), 2'd3, '0, '0, '0);
        chk("R7", "mask1 untouched", o_rd, em[1]);
        chk("R7", "legal read no err", 64'(o_err), 0);
    endtask

    task automatic t_illegal_wr();
        cyc(1, 1, slot_addr(5), 2'd3, '1, '0, '0);
        chk("R8", "req write err", 64'(o_err), 1);
        cyc(1, 1, slot_addr(8), 2'd3, '1, '0, '0);
        chk("R8", "raw write err", 64'(o_err), 1);
        cyc(1, 0, slot_addr(8), 2'd3, '0, '0, '0);
        chk("R8", "raw unchanged", o_rd, er);
        cyc(1, 0, slot_addr(5), 2'd3, '0, '0, '0);
        chk("R8", "req1 unchanged", o_rd, em[1] & er);
        chk_active("R8");
    endtask

    task automatic t_unmapped();
        cyc(1, 0, slot_addr(9), 2'd3, '0, '0, '0);
        chk("R6", "slot 9 err", 64'(o_err), 1);
        chk("R6", "slot 9 zero", o_rd, 0);
        cyc(1, 0, BASE - 32'd64, 2'd3, '0, '0, '0);
        chk("R6", "below base err", 64'(o_err), 1);
        chk("R6", "below base zero", o_rd, 0);
        cyc(1, 1, slot_addr(40), 2'd3, '1, '0, '0);
        chk("R6", "unmapped write err", 64'(o_err), 1);
    endtask

    task automatic t_collide();
        cyc(1, 1, slot_addr(3), 2'd3, 64'h400, 64'h400, '0);
        em[3] = 64'h400;
        er |= 64'h400;
        chk("R5", "mask+set same cycle cpu3", cpu_active[255:192], 64'h400);
        chk_active("R5");
        cyc(0, 0, '0, 2'd3, '0, 64'h800, 64'h800);
        er |= 64'h800;
        chk("R4", "set beats clear spur", 64'(o_spur), 0);
        cyc(1, 0, slot_addr(8), 2'd3, '0, '0, '0);
        chk("R4", "set beats clear raw", o_rd, er);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) em[c] = '0;
        er = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_rw();
        t_route();
        t_clear();
        t_mask_edge();
        t_size();
        t_illegal_wr();
        t_unmapped();
        t_collide();
        @(negedge clk);
        chk("R9", "final irq", 64'(cpu_irq), 64'(exp_irq()));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule